// File: doc/BRIEF.md
# SDRAM Device Burst Data Path

This block is the data side of a two-bank synchronous DRAM device model with a small storage array inside. It receives commands that are already decoded: read, write, burst terminate and precharge. With each command come a bank, a start column and an all-banks flag. The block also takes per-byte mask bits and three mode fields: CAS latency, burst length and burst order. For each burst it works out the column sequence. Read words leave the block after the programmed latency. Write words are stored as they arrive, and byte lanes whose mask bit is high are skipped. A new command can cut a running burst short, and the block applies the cutoff rule for each kind of interruption.

The read output is a stream whose valid qualifier is `rd_oe`, with one bit per byte lane. It has no ready signal. The CAS latency fixes the timing, so the consumer must accept every word in the cycle it is presented, and it applies back-pressure by issuing commands later. The write input has no handshake either: the block takes one word on every cycle of a write burst. A cycle is counted by its rising clock edge. A command presented before edge E is said to be "at edge E", and a value "after edge N" is the value the outputs hold between edge N and edge N+1. The command inputs are meant to be one-hot. If read and write arrive together, read wins.

Top module: `sdram_burst_path`

## Requirements
- R1: Word k (counting from 0) of a read at edge E appears on `rd_data` with `rd_oe` high after edge E+CL+k. CL is the value of `mode_cl`, where codes 1, 2 and 3 select that latency and code 0 acts as 1.
- R2: `mode_bl` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 words. No word of a burst is read or written beyond that count.
- R3: With `mode_ilv`=0 (sequential order), word k goes to the column whose low log2(BL) bits are (start + k) mod BL. The upper column bits stay as in the start column.
- R4: With `mode_ilv`=1 (interleaved order), word k goes to column start XOR k. Here k has log2(BL) bits.
- R5: A write at edge E stores `wr_data` at edge E into the start column, and word k is stored at edge E+k. Writes follow the same column order as reads.
- R6: A write word whose `dqm` bit i is high leaves byte lane i (bits 8i+7..8i) of that column unchanged.
- R7: A `dqm` bit i high at edge e drives `rd_oe[i]` low after edge e+2.
- R8: A read or write at any edge replaces the running burst from that edge onward, for the same bank or the other one. Write data at a cycle that carries a read command is not stored.
- R9: When a write at edge W interrupts a read, `rd_oe` is all low after edges W+2 onward. Read words due after W and W+1 are still delivered.
- R10: A terminate at edge P stops a burst. Read words issued before P still arrive, the last one after edge P+CL-1 at the latest. Write data at P and later is not stored.
- R11: A precharge ends the running burst only when `cmd_all` is high or `cmd_bank` names the burst's bank. A precharge to the other bank leaves the burst running.
- R12: While reset is held, and after it, `rd_oe` stays all low until a read produces data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| cmd_term | input | 1 | Burst terminate command |
| cmd_pre | input | 1 | Precharge command |
| cmd_all | input | 1 | With precharge: all banks |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_col | input | COL_W | Start column of a read or write |
| mode_cl | input | 2 | CAS latency code |
| mode_bl | input | 2 | Burst length code |
| mode_ilv | input | 1 | Burst order, 1 = interleaved |
| wr_data | input | DQ_W | Write data word |
| dqm | input | DQ_W/8 | Per-lane write mask and read output disable |
| rd_data | output | DQ_W | Read data word |
| rd_oe | output | DQ_W/8 | Per-lane output enable (read stream valid) |

## Verification
The bench builds the block with its defaults: a 16-bit word, two byte lanes, 8-bit columns and two banks. These sizes keep the whole lane-mask space and both banks within reach, and the column field is wide enough for sequential wrap inside an 8-word block and for interleaved XOR from an unaligned start. It runs every latency code (0 included), every burst length and both burst orders. It interrupts bursts at offsets of one to three cycles and compares the output-enable pattern cycle by cycle. This exposes the latency-dependent cutoffs after write, terminate and precharge, as well as the two-cycle read mask.

// File: rtl/sdbp_pkg.sv
package sdbp_pkg;
  // deepest CAS latency the output delay line supports
  localparam int MAX_CL = 3;
  // cycles from a mask bit to the output lane it disables
  localparam int MASK_LAT = 2;

  typedef enum logic [1:0] {
    BURST_NONE,
    BURST_RD,
    BURST_WR
  } burst_kind_e;

  // latency code 0 is treated as latency 1
  function automatic logic [1:0] cl_eff(input logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction
endpackage

// File: rtl/sdbp_burst_ctl.sv
module sdbp_burst_ctl
  import sdbp_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_term,
  input  logic              cmd_pre,
  input  logic              cmd_all,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [1:0]        mode_bl,
  input  logic              mode_ilv,
  output burst_kind_e       cur_kind,
  output logic [BANK_W-1:0] cur_bank,
  output logic [COL_W-1:0]  cur_col,
  output logic              burst_act
);
  localparam int IDX_W = 3;

  logic              act_q;
  burst_kind_e       kind_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  start_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        len_log_q;
  logic              ilv_q;

  logic new_cmd, stop_cmd, cont;

  // column of burst word k, inside the block aligned to the burst length
  function automatic logic [COL_W-1:0] order_col(
    input logic [COL_W-1:0] s,
    input logic [IDX_W-1:0] k,
    input logic [1:0]       lg,
    input logic             il
  );
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] kk;
    m  = COL_W'((1 << lg) - 1);
    kk = COL_W'(k) & m;
    if (il) order_col = s ^ kk;
    else    order_col = (s & ~m) | ((s + kk) & m);
  endfunction

  assign new_cmd  = cmd_rd | cmd_wr;
  assign stop_cmd = cmd_term | (cmd_pre & (cmd_all | (cmd_bank == bank_q)));
  assign cont     = act_q & ~new_cmd & ~stop_cmd;

  always_comb begin
    cur_kind = BURST_NONE;
    cur_bank = bank_q;
    cur_col  = order_col(start_q, idx_q, len_log_q, ilv_q);
    if (new_cmd) begin
      cur_kind = cmd_rd ? BURST_RD : BURST_WR;
      cur_bank = cmd_bank;
      cur_col  = cmd_col;
    end else if (cont) begin
      cur_kind = kind_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      kind_q    <= BURST_NONE;
      bank_q    <= '0;
      start_q   <= '0;
      idx_q     <= '0;
      len_log_q <= '0;
      ilv_q     <= 1'b0;
    end else if (new_cmd) begin
      act_q     <= (mode_bl != 2'd0);
      kind_q    <= cmd_rd ? BURST_RD : BURST_WR;
      bank_q    <= cmd_bank;
      start_q   <= cmd_col;
      idx_q     <= IDX_W'(1);
      len_log_q <= mode_bl;
      ilv_q     <= mode_ilv;
    end else if (cont) begin
      idx_q <= idx_q + 1'b1;
      act_q <= (({1'b0, idx_q} + 4'd1) < (4'd1 << len_log_q));
    end else begin
      act_q <= 1'b0;
    end
  end

  assign burst_act = act_q;
endmodule

// File: rtl/sdbp_store.sv
module sdbp_store #(
  parameter int DQ_W   = 16,
  parameter int LANES  = 2,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   wdata,
  output logic [DQ_W-1:0]   rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DQ_W / LANES;

  logic [DQ_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sdbp_rd_pipe.sv
module sdbp_rd_pipe
  import sdbp_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_cl,
  input  logic             rd_issue,
  input  logic             wr_cut,
  input  logic [DQ_W-1:0]  issue_data,
  input  logic [LANES-1:0] dqm,
  output logic [DQ_W-1:0]  rd_data,
  output logic [LANES-1:0] rd_oe
);
  localparam int DEPTH = MAX_CL + 1;

  logic [DQ_W-1:0]  st_d   [DEPTH];
  logic             st_v   [DEPTH];
  logic [LANES-1:0] mask_q [MASK_LAT+1];
  logic [1:0]       cl_sel;
  logic             out_v;

  assign cl_sel = cl_eff(mode_cl);

  // stage i holds a word issued i edges ago; a write drops every word
  // that would still surface two or more cycles after it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_d[i] <= '0;
        st_v[i] <= 1'b0;
      end
    end else begin
      st_d[0] <= issue_data;
      st_v[0] <= rd_issue;
      for (int i = 1; i < DEPTH; i++) begin
        st_d[i] <= st_d[i-1];
        st_v[i] <= st_v[i-1] && !(wr_cut && ((i + 2) <= int'(cl_sel)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= MASK_LAT; i++) mask_q[i] <= '0;
    end else begin
      mask_q[0] <= dqm;
      for (int i = 1; i <= MASK_LAT; i++) mask_q[i] <= mask_q[i-1];
    end
  end

  assign out_v   = st_v[cl_sel];
  assign rd_data = st_d[cl_sel];

  for (genvar g = 0; g < LANES; g++) begin : g_lane_oe
    assign rd_oe[g] = out_v & ~mask_q[MASK_LAT][g];
  end
endmodule

// File: rtl/sdram_burst_path.sv
module sdram_burst_path
  import sdbp_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int COL_W  = 8,
  parameter int BANK_W = 1,
  parameter int LANES  = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_term,
  input  logic              cmd_pre,
  input  logic              cmd_all,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [1:0]        mode_cl,
  input  logic [1:0]        mode_bl,
  input  logic              mode_ilv,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic [LANES-1:0]  dqm,
  output logic [DQ_W-1:0]   rd_data,
  output logic [LANES-1:0]  rd_oe
);
  localparam int ADDR_W = BANK_W + COL_W;

  burst_kind_e       cur_kind;
  logic [BANK_W-1:0] cur_bank;
  logic [COL_W-1:0]  cur_col;
  logic              burst_act;
  logic              cur_v;
  logic              rd_issue;
  logic [LANES-1:0]  lane_we;
  logic [DQ_W-1:0]   mem_q;

  sdbp_burst_ctl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .cmd_term (cmd_term),
    .cmd_pre  (cmd_pre),
    .cmd_all  (cmd_all),
    .cmd_bank (cmd_bank),
    .cmd_col  (cmd_col),
    .mode_bl  (mode_bl),
    .mode_ilv (mode_ilv),
    .cur_kind (cur_kind),
    .cur_bank (cur_bank),
    .cur_col  (cur_col),
    .burst_act(burst_act)
  );

  assign cur_v    = (cur_kind != BURST_NONE);
  assign rd_issue = (cur_kind == BURST_RD);
  assign lane_we  = (cur_kind == BURST_WR) ? ~dqm : '0;

  sdbp_store #(.DQ_W(DQ_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .lane_we(lane_we),
    .addr   ({cur_bank, cur_col}),
    .wdata  (wr_data),
    .rdata  (mem_q)
  );

  sdbp_rd_pipe #(.DQ_W(DQ_W), .LANES(LANES)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cl   (mode_cl),
    .rd_issue  (rd_issue),
    .wr_cut    (cmd_wr & ~cmd_rd),
    .issue_data(mem_q),
    .dqm       (dqm),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe)
  );
endmodule

// File: rtl/sdbp_checker.sv
module sdbp_checker
  import sdbp_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_term,
  input logic [1:0]       mode_cl,
  input logic [1:0]       mode_bl,
  input logic [LANES-1:0] dqm,
  input logic [LANES-1:0] rd_oe,
  input logic             cur_v,
  input logic             rd_issue,
  input logic             burst_act,
  input logic [LANES-1:0] lane_we
);
  logic [MAX_CL:0] hist_q;
  logic [3:0]      run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      run_q  <= '0;
    end else begin
      hist_q <= {hist_q[MAX_CL-1:0], rd_issue};
      if (cmd_rd || cmd_wr) run_q <= 4'd1;
      else if (cur_v)       run_q <= run_q + 4'd1;
      else                  run_q <= 4'd0;
    end
  end

  // R1: an enabled output lane traces back to a read issued CL cycles earlier
  a_r1_oe_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe != '0) |-> hist_q[cl_eff(mode_cl)]);

  // R2: a burst never runs past its programmed length
  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_v && !cmd_rd && !cmd_wr) |-> (run_q < (4'd1 << mode_bl)));

  // R5: the first write word is taken at the command edge
  a_r5_write_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rd) |-> (lane_we == ~dqm));

  // R7: a mask bit disables its lane two cycles later
  a_r7_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_oe & $past(dqm, 3)) == '0));

  // R9: a write silences read output from two cycles after it
  a_r9_write_cuts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rd) ##1 !cmd_rd |-> ##2 (rd_oe == '0));

  // R10: a terminate leaves no burst running
  a_r10_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_term && !cmd_rd && !cmd_wr) |=> !burst_act);
endmodule

bind sdram_burst_path sdbp_checker #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_rd   (cmd_rd),
  .cmd_wr   (cmd_wr),
  .cmd_term (cmd_term),
  .mode_cl  (mode_cl),
  .mode_bl  (mode_bl),
  .dqm      (dqm),
  .rd_oe    (rd_oe),
  .cur_v    (cur_v),
  .rd_issue (rd_issue),
  .burst_act(burst_act),
  .lane_we  (lane_we)
);

// File: tb/sdram_burst_path_tb.sv
module sdram_burst_path_tb;
  localparam int DQ_W   = 16;
  localparam int COL_W  = 8;
  localparam int BANK_W = 1;
  localparam int LANES  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_rd = 0, cmd_wr = 0, cmd_term = 0, cmd_pre = 0, cmd_all = 0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [COL_W-1:0]  cmd_col = '0;
  logic [1:0]        mode_cl = 2'd2, mode_bl = 2'd3;
  logic              mode_ilv = 1'b0;
  logic [DQ_W-1:0]   wr_data = '0;
  logic [LANES-1:0]  dqm = '0;
  logic [DQ_W-1:0]   rd_data;
  logic [LANES-1:0]  rd_oe;

  always #2.5 clk = ~clk;

  sdram_burst_path #(.DQ_W(DQ_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_term(cmd_term),
    .cmd_pre(cmd_pre), .cmd_all(cmd_all), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .mode_cl(mode_cl), .mode_bl(mode_bl), .mode_ilv(mode_ilv), .wr_data(wr_data),
    .dqm(dqm), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit run_mon = 0, done = 0;
  string tag = "";

  // reference model state
  logic [DQ_W-1:0]  mm [0:(1<<(COL_W+BANK_W))-1];
  logic [DQ_W-1:0]  exp_data [int];
  string            exp_tag  [int];
  logic [LANES-1:0] mask_at  [int];
  bit               m_act = 0, m_wr = 0, m_ilv = 0;
  logic [BANK_W-1:0] m_bank = '0;
  logic [COL_W-1:0]  m_start = '0;
  int               m_idx = 0, m_len = 1;

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int k, int len, bit il);
    int base, off;
    off  = int'(s) % len;
    base = int'(s) - off;
    if (il) return COL_W'(base + (off ^ k));
    return COL_W'(base + ((off + k) % len));
  endfunction

  function automatic logic [DQ_W-1:0] pat(int seed, int k);
    return DQ_W'(seed * 16'h0911 + k * 16'h0123 + 16'h3C5A);
  endfunction

  // driver: sets one cycle of inputs and pushes the expected outputs
  task automatic drive(bit rd, bit wr, bit term, bit pre, bit all,
                       logic [BANK_W-1:0] bank, logic [COL_W-1:0] col,
                       logic [DQ_W-1:0] wd, logic [LANES-1:0] dm);
    int e, clv, addr;
    bit cur, cw;
    logic [BANK_W-1:0] cb;
    logic [COL_W-1:0]  cc;
    @(negedge clk); #1;
    cmd_rd = rd; cmd_wr = wr; cmd_term = term; cmd_pre = pre; cmd_all = all;
    cmd_bank = bank; cmd_col = col; wr_data = wd; dqm = dm;
    e   = cyc + 1;
    clv = (mode_cl == 2'd0) ? 1 : int'(mode_cl);
    cur = 0; cw = 0; cb = '0; cc = '0;
    if (rd || wr) begin
      cur = 1; cw = wr && !rd; cb = bank; cc = col;
      m_len = 1 << mode_bl; m_ilv = mode_ilv; m_wr = cw; m_bank = bank;
      m_start = col; m_idx = 1; m_act = (m_len > 1);
    end else if (m_act && !(term || (pre && (all || bank == m_bank)))) begin
      cur = 1; cw = m_wr; cb = m_bank;
      cc = exp_col(m_start, m_idx, m_len, m_ilv);
      m_idx++;
      m_act = (m_idx < m_len);
    end else begin
      m_act = 0;
    end
    addr = int'(cb) * (1 << COL_W) + int'(cc);
    if (cur && cw) begin
      for (int l = 0; l < LANES; l++)
        if (!dm[l]) mm[addr][l*8 +: 8] = wd[l*8 +: 8];
    end
    if (cur && !cw) begin
      exp_data[e + clv] = mm[addr];
      exp_tag[e + clv]  = tag;
    end
    if (wr && !rd) begin
      for (int d = 2; d <= 3; d++)
        if (exp_data.exists(e + d)) begin exp_data.delete(e + d); exp_tag.delete(e + d); end
    end
    mask_at[e + 2] = dm;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, '0, '0, 16'hDEAD, '0);
  endtask

  task automatic rd_cmd(logic [BANK_W-1:0] b, logic [COL_W-1:0] c);
    drive(1, 0, 0, 0, 0, b, c, 16'hBEEF, '0);
  endtask

  // write command plus n-1 data cycles; the burst may run on past n
  task automatic wr_words(logic [BANK_W-1:0] b, logic [COL_W-1:0] c, int n, int seed);
    drive(0, 1, 0, 0, 0, b, c, pat(seed, 0), '0);
    for (int k = 1; k < n; k++) drive(0, 0, 0, 0, 0, '0, '0, pat(seed, k), '0);
  endtask

  task automatic set_mode(logic [1:0] cl, logic [1:0] bl, bit il);
    @(negedge clk); #1;
    cmd_rd = 0; cmd_wr = 0; cmd_term = 0; cmd_pre = 0; cmd_all = 0; dqm = '0;
    mode_cl = cl; mode_bl = bl; mode_ilv = il;
  endtask

  // monitor: compares outputs against the scoreboard every cycle
  always @(negedge clk) begin
    if (run_mon && !done) begin
      logic [LANES-1:0] eo;
      logic [DQ_W-1:0]  ed;
      string t;
      eo = '0; ed = '0; t = "R12 R10 no word due";
      if (exp_data.exists(cyc)) begin
        eo = mask_at.exists(cyc) ? ~mask_at[cyc] : '1;
        ed = exp_data[cyc];
        t  = exp_tag[cyc];
        exp_data.delete(cyc); exp_tag.delete(cyc);
      end
      if (mask_at.exists(cyc)) mask_at.delete(cyc);
      checks++;
      if (rd_oe !== eo) begin
        fails++;
        $display("FAIL %s: rd_oe=%b expected %b (cycle %0d)", t, rd_oe, eo, cyc);
      end else begin
        for (int l = 0; l < LANES; l++)
          if (eo[l] && rd_data[l*8 +: 8] !== ed[l*8 +: 8]) begin
            fails++;
            $display("FAIL %s: lane %0d data=%h expected %h (cycle %0d)",
                     t, l, rd_data[l*8 +: 8], ed[l*8 +: 8], cyc);
          end
      end
    end
  end

  initial begin
    for (int i = 0; i < (1 << (COL_W + BANK_W)); i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R12: outputs quiet under reset
    if (rd_oe !== '0) begin
      fails++;
      $display("FAIL R12: rd_oe=%b expected 00 during reset", rd_oe);
    end
    rst_n = 1'b1;
    run_mon = 1;

    // fill both banks, columns 0..31, with sequential BL8 write bursts (R5)
    set_mode(2'd2, 2'd3, 0);
    tag = "R5 fill";
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 32; s += 8) wr_words(BANK_W'(b), COL_W'(s), 8, b * 40 + s);
    nop(2);

    tag = "R1 R5 readback BL8 CL2";
    rd_cmd(0, 0); nop(10);
    rd_cmd(1, 16); nop(10);

    tag = "R3 R1 sequential wrap CL3";
    set_mode(2'd3, 2'd3, 0);
    rd_cmd(0, 13); nop(12);

    tag = "R4 R1 interleaved CL1";
    set_mode(2'd1, 2'd3, 1);
    rd_cmd(1, 5); nop(10);

    tag = "R2 R4 BL4 interleaved";
    set_mode(2'd2, 2'd2, 1);
    rd_cmd(0, 22); nop(8);
    tag = "R2 R3 BL2 sequential";
    set_mode(2'd2, 2'd1, 0);
    rd_cmd(0, 9); nop(6);
    tag = "R2 BL1";
    set_mode(2'd3, 2'd0, 0);
    rd_cmd(1, 30); nop(6);

    tag = "R6 write lane mask";
    set_mode(2'd2, 2'd2, 0);
    drive(0, 1, 0, 0, 0, 0, 4, pat(7, 0), 2'b00);
    drive(0, 0, 0, 0, 0, 0, 0, pat(7, 1), 2'b01);
    drive(0, 0, 0, 0, 0, 0, 0, pat(7, 2), 2'b10);
    drive(0, 0, 0, 0, 0, 0, 0, pat(7, 3), 2'b11);
    nop(2);
    rd_cmd(0, 4); nop(8);

    tag = "R7 read mask latency";
    set_mode(2'd3, 2'd2, 0);
    drive(1, 0, 0, 0, 0, 1, 0, 16'h0, 2'b01);
    drive(0, 0, 0, 0, 0, 0, 0, 16'h0, 2'b00);
    drive(0, 0, 0, 0, 0, 0, 0, 16'h0, 2'b10);
    drive(0, 0, 0, 0, 0, 0, 0, 16'h0, 2'b11);
    drive(0, 0, 0, 0, 0, 0, 0, 16'h0, 2'b01);
    nop(8);

    tag = "R8 read replaces read";
    set_mode(2'd2, 2'd3, 0);
    rd_cmd(0, 0); rd_cmd(1, 3); nop(2); rd_cmd(0, 17); nop(12);

    tag = "R9 write cuts read CL3";
    set_mode(2'd3, 2'd3, 0);
    rd_cmd(0, 8); nop(2);
    wr_words(1, 24, 8, 91); nop(4);
    tag = "R9 R5 readback after cut";
    rd_cmd(1, 24); nop(12);
    tag = "R9 write cuts read CL2";
    set_mode(2'd2, 2'd3, 0);
    rd_cmd(1, 0); nop(1);
    wr_words(0, 24, 8, 92); nop(4);

    tag = "R10 terminate read CL2";
    rd_cmd(0, 0); nop(2);
    drive(0, 0, 1, 0, 0, 0, 0, 16'h0, '0); nop(8);
    tag = "R10 precharge same bank CL3";
    set_mode(2'd3, 2'd3, 0);
    rd_cmd(1, 8); nop(3);
    drive(0, 0, 0, 1, 0, 1, 0, 16'h0, '0); nop(8);

    tag = "R11 precharge other bank keeps burst";
    rd_cmd(0, 16); nop(1);
    drive(0, 0, 0, 1, 0, 1, 0, 16'h0, '0); nop(10);
    tag = "R11 precharge all ends burst";
    rd_cmd(0, 16); nop(1);
    drive(0, 0, 0, 1, 1, 1, 0, 16'h0, '0); nop(8);

    tag = "R10 terminated write";
    set_mode(2'd2, 2'd3, 0);
    wr_words(0, 0, 3, 120);
    drive(0, 0, 1, 0, 0, 0, 0, pat(120, 3), '0);
    drive(0, 0, 0, 0, 0, 0, 0, pat(120, 4), '0);
    nop(2);
    rd_cmd(0, 0); nop(10);
    tag = "R8 write replaced by read";
    wr_words(1, 8, 2, 130);
    drive(1, 0, 0, 0, 0, 1, 8, pat(130, 2), '0);
    nop(12);

    tag = "R1 latency code 0 acts as 1";
    set_mode(2'd0, 2'd2, 0);
    rd_cmd(0, 4); nop(8);

    nop(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule